// File: doc/BRIEF.md
# Clock-Calendar Counter with Dual Copies

This block keeps the time of day and a 100-year calendar: seconds, minutes, hours, weekday, day of month, month and a two-digit year. Each single-cycle pulse on the one-second tick input moves the time forward by one second. Carries run through minutes, hours, days, months and years. Month lengths follow the calendar, and February takes 29 days in every year value divisible by four.

The stored bytes use one of two encodings, chosen by a mode input: plain binary or packed BCD. The hour byte can follow either a 24-hour or a 12-hour convention. An optional daylight-saving rule moves the hour forward one morning in spring and back one morning in autumn.

Two copies of the seven bytes exist. A working copy advances on every tick. A host-visible copy takes the advanced value only while the freeze input is low. A host write to a byte changes both copies. The host-visible copy can therefore be read steadily while the clock keeps running underneath it. A one-cycle pulse marks every tick whose result was copied to the host side.

Top module: `rtc_calendar`

## Requirements
- R1: After an asynchronous reset, the seconds, minutes, hours and year bytes read 00h, and the weekday, day-of-month and month bytes read 01h.
- R2: The encoding input selects binary when high and packed BCD (tens digit in bits 7:4, units in bits 3:0) when low. Seconds and minutes count 0..59, and in 24-hour mode hours count 0..23. Each field carries into the next field only when it wraps.
- R3: With the hour-format input low (12-hour mode), the hour byte holds 1..12 in bits 6:0 and a PM flag in bit 7. The sequence is 11 AM to 12 PM, 12 PM to 1 PM, and 11 PM to 12 AM, and the step from 11 PM to 12 AM also advances the date.
- R4: Day of month wraps to 1 after 31 in January, March, May, July, August, October and December, after 30 in April, June, September and November, and after 28 in February. In a year whose value is divisible by 4 (year 00 included), February wraps after 29 instead.
- R5: Weekday (1..7, 1 = Sunday) steps on each date advance and wraps from 7 to 1. Month wraps from 12 to 1 and then advances the year, and the year wraps from 99 to 00.
- R6: While the freeze input is high, a tick leaves every host-visible byte unchanged, but the working copy still advances. The first unfrozen tick then shows the working copy advanced by one more second.
- R7: A host write (select 0 = seconds, 1 = minutes, 2 = hours, 3 = weekday, 4 = day of month, 5 = month, 6 = year) loads the byte into both copies on the next edge. If a write and a tick fall in the same cycle, the written byte takes the written value and the other bytes take their advanced values.
- R8: With daylight saving enabled, on a Sunday in April with day of month 1..7, the second after 01:59:59 reads 03:00:00.
- R9: With daylight saving enabled, on a Sunday in October with day of month 25..31, the second after 01:59:59 reads 01:00:00 the first time only. A later pass through 01:59:59 on the same date proceeds to 02:00:00, and the one-time latch clears when the date advances.
- R10: The update-done output is high for exactly the one cycle after a tick that arrived while the freeze input was low, and it is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second advance pulse, one cycle wide |
| fmt_bin_i | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| dst_en_i | input | 1 | Daylight-saving rule enable |
| freeze_i | input | 1 | Hold host-visible copy |
| wr_en_i | input | 1 | Host byte write strobe |
| wr_sel_i | input | 3 | Byte select for the write |
| wr_data_i | input | 8 | Byte value to write |
| sec_o | output | 8 | Host-visible seconds |
| min_o | output | 8 | Host-visible minutes |
| hour_o | output | 8 | Host-visible hours |
| wday_o | output | 8 | Host-visible weekday |
| mday_o | output | 8 | Host-visible day of month |
| month_o | output | 8 | Host-visible month |
| year_o | output | 8 | Host-visible year |
| done_o | output | 1 | Pulse after a tick that was copied to the host side |

## Verification
A host write and a tick can land on the same edge. The bench provokes this by raising the write strobe for the seconds byte in the same cycle as the tick, at 10:59:59. The expected host-visible result is 11:00:05: minutes and hours take the carry from the advance, and seconds take the written value. Freezing and writing also combine: a write made while frozen must show at once, and the working copy must keep the seconds gained during the freeze.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W      = 8;
  localparam int NUM_BYTES   = 7;
  localparam int SEL_W       = $clog2(NUM_BYTES);
  localparam int SEC_LAST    = 59;
  localparam int HR_LAST     = 23;
  localparam int WDAY_LAST   = 7;
  localparam int MON_LAST    = 12;
  localparam int YR_LAST     = 99;
  localparam int LEAP_PERIOD = 4;
  localparam int DST_HOUR    = 1;
  localparam int SPRING_MON  = 4;
  localparam int FALL_MON    = 10;
  localparam int SPRING_DAY_MAX = 7;
  localparam int FALL_DAY_MIN   = 25;

  // decoded time, plain binary
  typedef struct packed {
    logic [6:0] yr;
    logic [3:0] mon;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
  } tm_t;

  function automatic logic [6:0] dec_byte(input logic [BYTE_W-1:0] b, input logic bin);
    if (bin) return b[6:0];
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [BYTE_W-1:0] enc_byte(input logic [6:0] v, input logic bin);
    logic [6:0] tens;
    logic [6:0] units;
    tens  = v / 7'd10;
    units = v % 7'd10;
    if (bin) return {1'b0, v};
    return {tens[3:0], units[3:0]};
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [6:0] yr);
    case (mon)
      4'd2:                       month_len = ((yr % 7'(LEAP_PERIOD)) == 7'd0) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:    month_len = 5'd30;
      default:                    month_len = 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_decode.sv
module rtc_decode
  import rtc_pkg::*;
(
  input  logic [NUM_BYTES-1:0][BYTE_W-1:0] bytes_i,
  input  logic                             bin_i,
  input  logic                             hr24_i,
  output tm_t                              tm_o
);
  logic [6:0] h12;
  logic [6:0] h24;
  logic [BYTE_W-1:0] hb;

  assign hb = bytes_i[2];

  always_comb begin
    h12 = dec_byte({1'b0, hb[6:0]}, bin_i);
    if (hr24_i)          h24 = dec_byte(hb, bin_i);
    else if (h12 == 7'd12) h24 = hb[7] ? 7'd12 : 7'd0;
    else                 h24 = h12 + (hb[7] ? 7'd12 : 7'd0);
  end

  always_comb begin
    tm_o.sec  = 6'(dec_byte(bytes_i[0], bin_i));
    tm_o.min  = 6'(dec_byte(bytes_i[1], bin_i));
    tm_o.hr   = h24[4:0];
    tm_o.wday = 3'(dec_byte(bytes_i[3], bin_i));
    tm_o.mday = 5'(dec_byte(bytes_i[4], bin_i));
    tm_o.mon  = 4'(dec_byte(bytes_i[5], bin_i));
    tm_o.yr   = dec_byte(bytes_i[6], bin_i);
  end
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_pkg::*;
(
  input  tm_t  cur_i,
  input  logic dst_en_i,
  input  logic fell_i,
  output tm_t  nxt_o,
  output logic day_roll_o,
  output logic fall_hit_o
);
  logic sec_wrap, min_wrap, hr_wrap, hour_end, sunday, at_dst_hr;
  logic spring, fall;

  assign sec_wrap  = cur_i.sec >= 6'(SEC_LAST);
  assign min_wrap  = cur_i.min >= 6'(SEC_LAST);
  assign hr_wrap   = cur_i.hr  >= 5'(HR_LAST);
  assign hour_end  = sec_wrap && min_wrap;
  assign sunday    = cur_i.wday == 3'd1;
  assign at_dst_hr = dst_en_i && hour_end && sunday && (cur_i.hr == 5'(DST_HOUR));
  assign spring    = at_dst_hr && (cur_i.mon == 4'(SPRING_MON)) &&
                     (cur_i.mday <= 5'(SPRING_DAY_MAX));
  assign fall      = at_dst_hr && (cur_i.mon == 4'(FALL_MON)) &&
                     (cur_i.mday >= 5'(FALL_DAY_MIN)) && !fell_i;

  always_comb begin
    nxt_o      = cur_i;
    day_roll_o = 1'b0;
    fall_hit_o = 1'b0;
    nxt_o.sec  = sec_wrap ? 6'd0 : cur_i.sec + 6'd1;
    if (sec_wrap) nxt_o.min = min_wrap ? 6'd0 : cur_i.min + 6'd1;
    if (hour_end) begin
      if (spring)       nxt_o.hr = 5'(DST_HOUR + 2);
      else if (fall) begin
        nxt_o.hr   = 5'(DST_HOUR);
        fall_hit_o = 1'b1;
      end else if (hr_wrap) begin
        nxt_o.hr   = 5'd0;
        day_roll_o = 1'b1;
      end else      nxt_o.hr = cur_i.hr + 5'd1;
    end
    if (day_roll_o) begin
      nxt_o.wday = (cur_i.wday >= 3'(WDAY_LAST)) ? 3'd1 : cur_i.wday + 3'd1;
      if (cur_i.mday >= month_len(cur_i.mon, cur_i.yr)) begin
        nxt_o.mday = 5'd1;
        if (cur_i.mon >= 4'(MON_LAST)) begin
          nxt_o.mon = 4'd1;
          nxt_o.yr  = (cur_i.yr >= 7'(YR_LAST)) ? 7'd0 : cur_i.yr + 7'd1;
        end else nxt_o.mon = cur_i.mon + 4'd1;
      end else nxt_o.mday = cur_i.mday + 5'd1;
    end
  end
endmodule

// File: rtl/rtc_encode.sv
module rtc_encode
  import rtc_pkg::*;
(
  input  tm_t                              tm_i,
  input  logic                             bin_i,
  input  logic                             hr24_i,
  output logic [NUM_BYTES-1:0][BYTE_W-1:0] bytes_o
);
  logic [6:0] hr7;
  logic [6:0] h12;
  logic [BYTE_W-1:0] h12_enc;

  assign hr7 = {2'b00, tm_i.hr};

  always_comb begin
    if (hr7 == 7'd0)       h12 = 7'd12;
    else if (hr7 > 7'd12)  h12 = hr7 - 7'd12;
    else                   h12 = hr7;
    h12_enc = enc_byte(h12, bin_i);
  end

  always_comb begin
    bytes_o[0] = enc_byte({1'b0, tm_i.sec}, bin_i);
    bytes_o[1] = enc_byte({1'b0, tm_i.min}, bin_i);
    bytes_o[2] = hr24_i ? enc_byte(hr7, bin_i) : {(hr7 >= 7'd12), h12_enc[6:0]};
    bytes_o[3] = enc_byte({4'd0, tm_i.wday}, bin_i);
    bytes_o[4] = enc_byte({2'd0, tm_i.mday}, bin_i);
    bytes_o[5] = enc_byte({3'd0, tm_i.mon}, bin_i);
    bytes_o[6] = enc_byte(tm_i.yr, bin_i);
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              fmt_bin_i,
  input  logic              hr24_i,
  input  logic              dst_en_i,
  input  logic              freeze_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] sec_o,
  output logic [BYTE_W-1:0] min_o,
  output logic [BYTE_W-1:0] hour_o,
  output logic [BYTE_W-1:0] wday_o,
  output logic [BYTE_W-1:0] mday_o,
  output logic [BYTE_W-1:0] month_o,
  output logic [BYTE_W-1:0] year_o,
  output logic              done_o
);
  localparam logic [NUM_BYTES-1:0][BYTE_W-1:0] RST_BYTES =
    {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  logic [BYTE_W-1:0] wrk_q [NUM_BYTES];
  logic [BYTE_W-1:0] usr_q [NUM_BYTES];
  logic [NUM_BYTES-1:0][BYTE_W-1:0] wrk_vec, wrk_adv;
  tm_t  cur_tm, nxt_tm;
  logic day_roll, fall_hit, fell_q, done_q;

  rtc_decode u_dec (
    .bytes_i (wrk_vec),
    .bin_i   (fmt_bin_i),
    .hr24_i  (hr24_i),
    .tm_o    (cur_tm)
  );

  rtc_advance u_adv (
    .cur_i      (cur_tm),
    .dst_en_i   (dst_en_i),
    .fell_i     (fell_q),
    .nxt_o      (nxt_tm),
    .day_roll_o (day_roll),
    .fall_hit_o (fall_hit)
  );

  rtc_encode u_enc (
    .tm_i    (nxt_tm),
    .bin_i   (fmt_bin_i),
    .hr24_i  (hr24_i),
    .bytes_o (wrk_adv)
  );

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    logic hit;
    assign hit        = wr_en_i && (wr_sel_i == SEL_W'(g));
    assign wrk_vec[g] = wrk_q[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wrk_q[g] <= RST_BYTES[g];
        usr_q[g] <= RST_BYTES[g];
      end else if (hit) begin
        wrk_q[g] <= wr_data_i;
        usr_q[g] <= wr_data_i;
      end else begin
        if (tick_i)              wrk_q[g] <= wrk_adv[g];
        if (tick_i && !freeze_i) usr_q[g] <= wrk_adv[g];
      end
    end
  end

  // fall-back happens once per date
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fell_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= tick_i && !freeze_i;
      if (tick_i) begin
        if (day_roll)      fell_q <= 1'b0;
        else if (fall_hit) fell_q <= 1'b1;
      end
    end
  end

  assign sec_o   = usr_q[0];
  assign min_o   = usr_q[1];
  assign hour_o  = usr_q[2];
  assign wday_o  = usr_q[3];
  assign mday_o  = usr_q[4];
  assign month_o = usr_q[5];
  assign year_o  = usr_q[6];
  assign done_o  = done_q;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              freeze_i,
  input logic              wr_en_i,
  input logic [SEL_W-1:0]  wr_sel_i,
  input logic [BYTE_W-1:0] wr_data_i,
  input logic [BYTE_W-1:0] sec_o,
  input logic [BYTE_W-1:0] min_o,
  input logic [BYTE_W-1:0] hour_o,
  input logic [BYTE_W-1:0] wday_o,
  input logic [BYTE_W-1:0] mday_o,
  input logic [BYTE_W-1:0] month_o,
  input logic [BYTE_W-1:0] year_o,
  input logic              done_o
);
  logic [NUM_BYTES*BYTE_W-1:0] vis;
  assign vis = {year_o, month_o, mday_o, wday_o, hour_o, min_o, sec_o};

  assert_done_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(tick_i) && !$past(freeze_i)));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_freeze_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && freeze_i && !wr_en_i) |=> $stable(vis));

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> $stable(vis));

  assert_sec_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == '0) |=> (sec_o == $past(wr_data_i)));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (.*);

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [55:0] bytes;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, fmt_bin = 1'b0, hr24 = 1'b1, dst_en = 1'b0, freeze = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec, mins, hour, wday, mday, month, year;
  logic done;
  int checks = 0, errors = 0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .fmt_bin_i(fmt_bin), .hr24_i(hr24),
    .dst_en_i(dst_en), .freeze_i(freeze), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .sec_o(sec), .min_o(mins), .hour_o(hour), .wday_o(wday),
    .mday_o(mday), .month_o(month), .year_o(year), .done_o(done)
  );

  function automatic logic [55:0] pk(input logic [7:0] y, mo, md, wd, h, mi, s);
    return {y, mo, md, wd, h, mi, s};
  endfunction

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: compare queued expectations away from the edge
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() != 0) begin
        it = sb_q.pop_front();
        checks++;
        if ({year, month, mday, wday, hour, mins, sec} !== it.bytes) begin
          errors++;
          $display("FAIL %s act %h exp %h", it.tag,
                   {year, month, mday, wday, hour, mins, sec}, it.bytes);
        end
      end
    end
  end

  task automatic push(input logic [55:0] e, input string tag);
    exp_t it;
    it.bytes = e;
    it.tag   = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] y, mo, md, wd, h, mi, s);
    wr(3'd6, y); wr(3'd5, mo); wr(3'd4, md); wr(3'd3, wd);
    wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
  endtask

  task automatic run_tick(input logic [55:0] e, input string tag, input logic exp_done,
                          input logic do_wr, input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    tick = 1'b1;
    if (do_wr) begin wr_en = 1'b1; wr_sel = sel; wr_data = d; end
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    checks++;
    if (done !== exp_done) begin
      errors++;
      $display("FAIL R10 done %s act %b exp %b", tag, done, exp_done);
    end
    push(e, tag);
  endtask

  task automatic tk(input logic [55:0] e, input string tag);
    run_tick(e, tag, 1'b1, 1'b0, 3'd0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog act hung exp done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push(pk(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), "R1 reset");

    // BCD 24h full rollover
    fmt_bin = 1'b0; hr24 = 1'b1;
    set_all(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
    tk(pk(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), "R5 R2 year wrap bcd");
    set_all(8'h21, 8'h05, 8'h09, 8'h01, 8'h09, 8'h09, 8'h59);
    tk(pk(8'h21, 8'h05, 8'h09, 8'h01, 8'h09, 8'h10, 8'h00), "R2 bcd tens carry");
    set_all(8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    tk(pk(8'h00, 8'h02, 8'h29, 8'h03, 8'h00, 8'h00, 8'h00), "R4 year 00 leap");
    set_all(8'h21, 8'h04, 8'h30, 8'h04, 8'h23, 8'h59, 8'h59);
    tk(pk(8'h21, 8'h05, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00), "R4 april 30");

    // binary
    fmt_bin = 1'b1;
    set_all(8'h18, 8'h02, 8'h1C, 8'h03, 8'h17, 8'h3B, 8'h3B);
    tk(pk(8'h18, 8'h02, 8'h1D, 8'h04, 8'h00, 8'h00, 8'h00), "R4 leap feb 28 bin");
    wr(3'd2, 8'h17); wr(3'd1, 8'h3B); wr(3'd0, 8'h3B);
    tk(pk(8'h18, 8'h03, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00), "R4 leap feb 29 bin");
    set_all(8'h19, 8'h02, 8'h1C, 8'h07, 8'h17, 8'h3B, 8'h3B);
    tk(pk(8'h19, 8'h03, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), "R4 R5 common feb bin");
    set_all(8'h19, 8'h03, 8'h01, 8'h02, 8'h05, 8'h0A, 8'h3B);
    tk(pk(8'h19, 8'h03, 8'h01, 8'h02, 8'h05, 8'h0B, 8'h00), "R2 bin minute carry");

    // 12-hour
    fmt_bin = 1'b0; hr24 = 1'b0;
    set_all(8'h21, 8'h05, 8'h09, 8'h01, 8'h11, 8'h59, 8'h59);
    tk(pk(8'h21, 8'h05, 8'h09, 8'h01, 8'h92, 8'h00, 8'h00), "R3 11am to 12pm");
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tk(pk(8'h21, 8'h05, 8'h09, 8'h01, 8'h81, 8'h00, 8'h00), "R3 12pm to 1pm");
    wr(3'd2, 8'h91); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tk(pk(8'h21, 8'h05, 8'h10, 8'h02, 8'h12, 8'h00, 8'h00), "R3 11pm to 12am");
    fmt_bin = 1'b1;
    set_all(8'h15, 8'h01, 8'h05, 8'h03, 8'h0B, 8'h3B, 8'h3B);
    tk(pk(8'h15, 8'h01, 8'h05, 8'h03, 8'h8C, 8'h00, 8'h00), "R3 bin 11am to 12pm");

    // freeze
    fmt_bin = 1'b0; hr24 = 1'b1;
    set_all(8'h22, 8'h06, 8'h01, 8'h04, 8'h08, 8'h00, 8'h00);
    freeze = 1'b1;
    run_tick(pk(8'h22, 8'h06, 8'h01, 8'h04, 8'h08, 8'h00, 8'h00), "R6 frozen 1", 1'b0, 1'b0, 3'd0, 8'h00);
    run_tick(pk(8'h22, 8'h06, 8'h01, 8'h04, 8'h08, 8'h00, 8'h00), "R6 frozen 2", 1'b0, 1'b0, 3'd0, 8'h00);
    wr(3'd1, 8'h30);
    push(pk(8'h22, 8'h06, 8'h01, 8'h04, 8'h08, 8'h30, 8'h00), "R7 write while frozen");
    freeze = 1'b0;
    tk(pk(8'h22, 8'h06, 8'h01, 8'h04, 8'h08, 8'h30, 8'h03), "R6 R7 unfreeze");

    // collision of write and tick
    set_all(8'h22, 8'h06, 8'h01, 8'h04, 8'h10, 8'h59, 8'h59);
    run_tick(pk(8'h22, 8'h06, 8'h01, 8'h04, 8'h11, 8'h00, 8'h05), "R7 write with tick", 1'b1, 1'b1, 3'd0, 8'h05);

    // daylight saving, spring
    dst_en = 1'b1;
    set_all(8'h22, 8'h04, 8'h03, 8'h01, 8'h01, 8'h59, 8'h59);
    tk(pk(8'h22, 8'h04, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00), "R8 spring forward");
    set_all(8'h22, 8'h04, 8'h04, 8'h02, 8'h01, 8'h59, 8'h59);
    tk(pk(8'h22, 8'h04, 8'h04, 8'h02, 8'h02, 8'h00, 8'h00), "R8 not sunday");
    hr24 = 1'b0;
    set_all(8'h22, 8'h04, 8'h03, 8'h01, 8'h01, 8'h59, 8'h59);
    tk(pk(8'h22, 8'h04, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00), "R8 spring 12h");

    // daylight saving, fall
    hr24 = 1'b1;
    set_all(8'h22, 8'h10, 8'h30, 8'h01, 8'h01, 8'h59, 8'h59);
    tk(pk(8'h22, 8'h10, 8'h30, 8'h01, 8'h01, 8'h00, 8'h00), "R9 fall back");
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tk(pk(8'h22, 8'h10, 8'h30, 8'h01, 8'h02, 8'h00, 8'h00), "R9 second pass");
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tk(pk(8'h22, 8'h10, 8'h31, 8'h02, 8'h00, 8'h00, 8'h00), "R9 day roll");
    set_all(8'h22, 8'h10, 8'h30, 8'h01, 8'h01, 8'h59, 8'h59);
    tk(pk(8'h22, 8'h10, 8'h30, 8'h01, 8'h01, 8'h00, 8'h00), "R9 latch cleared");
    dst_en = 1'b0;
    set_all(8'h22, 8'h10, 8'h30, 8'h01, 8'h01, 8'h59, 8'h59);
    tk(pk(8'h22, 8'h10, 8'h30, 8'h01, 8'h02, 8'h00, 8'h00), "R9 disabled");

    @(negedge clk);
    checks++;
    if (done !== 1'b0) begin
      errors++;
      $display("FAIL R10 idle done act %b exp 0", done);
    end
    wait (sb_q.size() == 0);
    repeat (2) @(negedge clk);
    report();
  end
endmodule